// File: doc/BRIEF.md
# Prefetch Request Queue

This block sits between a prefetch address generator and the memory-side request path of a cache. It holds block-aligned prefetch candidates, each with the time at which it may be issued. On every demand access the cache sends a notify. The queue then drops any pending entry for the block being demanded. It can optionally squash younger entries that have not matured yet. Last, it admits the new candidates from the generator, filtering out blocks that are already cached, already outstanding in the miss queue, or already queued.

Storage is a fixed number of slots kept packed from the head. When a candidate arrives at a full queue, the oldest entry is evicted to make room; the new candidate is never refused. The memory side pops the head through a valid/ready handshake and reads the head's ready time from a next-ready output. Four event counters record demand removals, squashes, duplicate hits and full evictions.

Top module: `pf_req_queue`

## Requirements
- R1: After reset the queue is empty: `pop_valid` is 0, `next_ready` is all ones, `rpt_valid` is 0 and all four counters are 0.
- R2: A notify with `ntf_uncache` set causes no change to the queue or the counters. A notify with `ntf_ifetch` set while `cfg_data_only` is 1 also causes no change. With `cfg_data_only` 0, instruction-fetch notifies are processed normally.
- R3: A processed notify aligns `ntf_addr` down to the block size (low log2(BLK_BYTES) bits cleared). If an entry for that block is queued, the notify removes it and increments `cnt_demand` by one.
- R4: With `cfg_serial_squash` set, after the demand removal a processed notify removes entries from the tail. Removal continues while the tail's ready time is greater than or equal to `ntf_time` (unsigned). Each removal adds one to `cnt_squash`. With the mode clear, `cnt_squash` never changes.
- R5: Candidates are aligned down to the block size and handled in index order 0 upward. A candidate whose `cand_in_missq` bit is set is dropped. A candidate whose block is already queued, including one added by a lower index in the same notify, is dropped and adds one to `cnt_bufhit`.
- R6: With `cfg_check_push` set, a candidate whose `cand_in_cache` bit is set is dropped on insertion. With it clear, the head is looked up through `head_lkp_addr` and `head_lkp_in_cache`. A cached head is not offered on `pop_valid` and is discarded on that cycle's clock edge when no notify is present.
- R7: When a candidate must be inserted into a queue holding DEPTH entries, the head entry is discarded first and `cnt_full` increments by one. The occupancy never exceeds DEPTH.
- R8: An admitted candidate's ready time is `ntf_time` plus its `cand_delay`, and it is appended at the tail. Entries are popped in arrival order, and `pop_addr` shows the head's block address.
- R9: One cycle after any notify, `rpt_valid` is 1 and `rpt_time` holds the head's ready time after that notify was processed, or 0 if the queue is then empty. `rpt_valid` is 0 after a cycle without a notify.
- R10: `next_ready` shows the head entry's ready time, or all ones when the queue is empty.
- R11: `pop_valid` is asserted only when the queue is non-empty and no notify is present. In that cycle a notify takes precedence and the pop stalls. A handshake with `pop_ready` removes exactly the head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_data_only | input | 1 | Ignore instruction-fetch notifies |
| cfg_serial_squash | input | 1 | Squash unmatured tail entries on notify |
| cfg_check_push | input | 1 | Cache check at insertion (1) or at pop (0) |
| ntf_valid | input | 1 | Demand access notify |
| ntf_addr | input | ADDR_W | Demand byte address |
| ntf_time | input | TIME_W | Current time of the access |
| ntf_uncache | input | 1 | Demand access is uncacheable |
| ntf_ifetch | input | 1 | Demand access is an instruction fetch |
| cand_valid | input | NCAND | Candidate present, one bit per slot |
| cand_addr | input | NCAND*ADDR_W | Candidate byte addresses, slot c at bits c*ADDR_W |
| cand_delay | input | NCAND*DLY_W | Candidate delays, slot c at bits c*DLY_W |
| cand_in_cache | input | NCAND | Candidate block is present in the cache |
| cand_in_missq | input | NCAND | Candidate block is present in the miss queue |
| head_lkp_addr | output | ADDR_W | Head block address sent to the cache lookup |
| head_lkp_in_cache | input | 1 | Cache lookup result for head_lkp_addr |
| pop_valid | output | 1 | Head entry offered for issue |
| pop_ready | input | 1 | Memory side accepts the head |
| pop_addr | output | ADDR_W | Block address of the head |
| rpt_valid | output | 1 | Notify report strobe |
| rpt_time | output | TIME_W | Head ready time after the last notify, 0 if empty |
| next_ready | output | TIME_W | Head ready time, all ones if empty |
| cnt_demand | output | CNT_W | Entries removed by demand accesses |
| cnt_squash | output | CNT_W | Entries removed by serial squash |
| cnt_bufhit | output | CNT_W | Candidates already queued |
| cnt_full | output | CNT_W | Entries evicted because the queue was full |

## Verification
A corrupted slot or a wrong occupancy shows on `next_ready` right after the clock edge that caused it. The fault is visible before the entry is ever popped. An entry left behind or removed twice shows up in one of two places. The first is the `pop_addr` sequence at the next handshake. The second is a counter that drifts one cycle after the notify. A wrong choice between squash, eviction and duplicate filtering changes the counters in the same cycle that the queue contents diverge. A reference queue in the bench therefore pins a fault to the notify that caused it.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

  typedef enum logic [1:0] {
    EV_DEMAND = 2'd0,
    EV_SQUASH = 2'd1,
    EV_BUFHIT = 2'd2,
    EV_FULL   = 2'd3
  } pfq_event_e;

  localparam int PFQ_NEVENT = 4;

  function automatic int pfq_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pfq_notify_gate.sv
module pfq_notify_gate #(
  parameter int ADDR_W    = 32,
  parameter int BLK_BYTES = 64
) (
  input  logic              ntf_valid,
  input  logic [ADDR_W-1:0] ntf_addr,
  input  logic              ntf_uncache,
  input  logic              ntf_ifetch,
  input  logic              cfg_data_only,
  output logic              act,
  output logic [ADDR_W-1:0] dm_blk
);
  localparam int OFS_W = $clog2(BLK_BYTES);

  // uncacheable accesses and (optionally) fetches leave the queue untouched
  assign act    = ntf_valid && !ntf_uncache && !(ntf_ifetch && cfg_data_only);
  assign dm_blk = {ntf_addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
endmodule

// File: rtl/pfq_cand_filter.sv
module pfq_cand_filter #(
  parameter int ADDR_W    = 32,
  parameter int TIME_W    = 32,
  parameter int DLY_W     = 8,
  parameter int BLK_BYTES = 64,
  parameter int NCAND     = 2
) (
  input  logic                    act,
  input  logic                    cfg_check_push,
  input  logic [TIME_W-1:0]       now,
  input  logic [NCAND-1:0]        cand_valid,
  input  logic [NCAND*ADDR_W-1:0] cand_addr,
  input  logic [NCAND*DLY_W-1:0]  cand_delay,
  input  logic [NCAND-1:0]        cand_in_cache,
  input  logic [NCAND-1:0]        cand_in_missq,
  output logic [NCAND-1:0]        keep,
  output logic [NCAND*ADDR_W-1:0] c_blk,
  output logic [NCAND*TIME_W-1:0] c_rdy
);
  localparam int OFS_W = $clog2(BLK_BYTES);

  for (genvar c = 0; c < NCAND; c++) begin : g_slot
    logic [ADDR_W-1:0] raw;
    assign raw  = cand_addr[c*ADDR_W +: ADDR_W];
    // external presence filters; queue duplicates are handled by the array
    assign keep[c] = act && cand_valid[c] && !cand_in_missq[c] &&
                     !(cfg_check_push && cand_in_cache[c]);
    assign c_blk[c*ADDR_W +: ADDR_W] = {raw[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
    assign c_rdy[c*TIME_W +: TIME_W] = now + TIME_W'(cand_delay[c*DLY_W +: DLY_W]);
  end
endmodule

// File: rtl/pfq_stats.sv
module pfq_stats #(
  parameter int CNT_W  = 16,
  parameter int INC_W  = 4,
  parameter int NEVENT = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NEVENT*INC_W-1:0]  inc,
  output logic [NEVENT*CNT_W-1:0]  cnt
);
  for (genvar e = 0; e < NEVENT; e++) begin : g_ctr
    always_ff @(posedge clk) begin
      if (rst) cnt[e*CNT_W +: CNT_W] <= '0;
      else     cnt[e*CNT_W +: CNT_W] <= cnt[e*CNT_W +: CNT_W] + CNT_W'(inc[e*INC_W +: INC_W]);
    end
  end
endmodule

// File: rtl/pf_req_queue.sv
module pf_req_queue #(
  parameter int ADDR_W    = 32,
  parameter int TIME_W    = 32,
  parameter int DLY_W     = 8,
  parameter int DEPTH     = 8,
  parameter int NCAND     = 2,
  parameter int BLK_BYTES = 64,
  parameter int CNT_W     = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_data_only,
  input  logic                    cfg_serial_squash,
  input  logic                    cfg_check_push,
  input  logic                    ntf_valid,
  input  logic [ADDR_W-1:0]       ntf_addr,
  input  logic [TIME_W-1:0]       ntf_time,
  input  logic                    ntf_uncache,
  input  logic                    ntf_ifetch,
  input  logic [NCAND-1:0]        cand_valid,
  input  logic [NCAND*ADDR_W-1:0] cand_addr,
  input  logic [NCAND*DLY_W-1:0]  cand_delay,
  input  logic [NCAND-1:0]        cand_in_cache,
  input  logic [NCAND-1:0]        cand_in_missq,
  output logic [ADDR_W-1:0]       head_lkp_addr,
  input  logic                    head_lkp_in_cache,
  output logic                    pop_valid,
  input  logic                    pop_ready,
  output logic [ADDR_W-1:0]       pop_addr,
  output logic                    rpt_valid,
  output logic [TIME_W-1:0]       rpt_time,
  output logic [TIME_W-1:0]       next_ready,
  output logic [CNT_W-1:0]        cnt_demand,
  output logic [CNT_W-1:0]        cnt_squash,
  output logic [CNT_W-1:0]        cnt_bufhit,
  output logic [CNT_W-1:0]        cnt_full
);
  import pfq_pkg::*;

  localparam int CW    = $clog2(DEPTH + 1);
  localparam int IW    = $clog2(DEPTH);
  localparam int SQW   = $clog2(DEPTH + 1);
  localparam int CFW   = $clog2(NCAND + 1);
  localparam int INC_W = pfq_max(SQW, CFW);

  // registered queue state, head at slot 0
  logic [ADDR_W-1:0] qa [DEPTH];
  logic [TIME_W-1:0] qt [DEPTH];
  logic [CW-1:0]     q_n;

  // next-state working copy
  logic [ADDR_W-1:0] wa [DEPTH];
  logic [TIME_W-1:0] wt [DEPTH];
  logic [CW-1:0]     wn;

  logic              act;
  logic [ADDR_W-1:0] dm_blk;
  logic [NCAND-1:0]        keep;
  logic [NCAND*ADDR_W-1:0] c_blk;
  logic [NCAND*TIME_W-1:0] c_rdy;

  logic              hit, stop, dup;
  logic [IW-1:0]     hidx;
  logic              inc_dem;
  logic [SQW-1:0]    inc_sq;
  logic [CFW-1:0]    inc_bh, inc_full;
  logic              pop_fire, head_skip;
  logic [PFQ_NEVENT*INC_W-1:0] inc_vec;
  logic [PFQ_NEVENT*CNT_W-1:0] cnt_vec;

  pfq_notify_gate #(.ADDR_W(ADDR_W), .BLK_BYTES(BLK_BYTES)) u_gate (
    .ntf_valid    (ntf_valid),
    .ntf_addr     (ntf_addr),
    .ntf_uncache  (ntf_uncache),
    .ntf_ifetch   (ntf_ifetch),
    .cfg_data_only(cfg_data_only),
    .act          (act),
    .dm_blk       (dm_blk)
  );

  pfq_cand_filter #(
    .ADDR_W(ADDR_W), .TIME_W(TIME_W), .DLY_W(DLY_W),
    .BLK_BYTES(BLK_BYTES), .NCAND(NCAND)
  ) u_filt (
    .act           (act),
    .cfg_check_push(cfg_check_push),
    .now           (ntf_time),
    .cand_valid    (cand_valid),
    .cand_addr     (cand_addr),
    .cand_delay    (cand_delay),
    .cand_in_cache (cand_in_cache),
    .cand_in_missq (cand_in_missq),
    .keep          (keep),
    .c_blk         (c_blk),
    .c_rdy         (c_rdy)
  );

  // pop side: notify has priority; pop-time cache check when push check is off
  assign head_lkp_addr = qa[0];
  assign pop_addr      = qa[0];
  assign pop_valid     = (q_n != '0) && !ntf_valid && (cfg_check_push || !head_lkp_in_cache);
  assign head_skip     = (q_n != '0) && !ntf_valid && !cfg_check_push && head_lkp_in_cache;
  assign pop_fire      = pop_valid && pop_ready;
  assign next_ready    = (q_n == '0) ? '1 : qt[0];

  always_comb begin
    wa = qa;
    wt = qt;
    wn = q_n;
    inc_dem  = 1'b0;
    inc_sq   = '0;
    inc_bh   = '0;
    inc_full = '0;
    hit  = 1'b0;
    hidx = '0;
    stop = 1'b0;
    dup  = 1'b0;
    if (act) begin
      // 1) demand removal of a matching block
      for (int i = 0; i < DEPTH; i++) begin
        if (CW'(i) < wn && wa[i] == dm_blk) begin
          hit  = 1'b1;
          hidx = IW'(i);
        end
      end
      if (hit) begin
        for (int j = 0; j < DEPTH - 1; j++) begin
          if (IW'(j) >= hidx) begin
            wa[j] = wa[j+1];
            wt[j] = wt[j+1];
          end
        end
        wn      = wn - 1'b1;
        inc_dem = 1'b1;
      end
      // 2) serial squash from the tail
      if (cfg_serial_squash) begin
        for (int k = DEPTH - 1; k >= 0; k--) begin
          if (!stop && wn != '0 && CW'(k) == wn - 1'b1) begin
            if (wt[k] >= ntf_time) begin
              wn     = wn - 1'b1;
              inc_sq = inc_sq + 1'b1;
            end else begin
              stop = 1'b1;
            end
          end
        end
      end
      // 3) candidate admission in slot order
      for (int c = 0; c < NCAND; c++) begin
        if (keep[c]) begin
          dup = 1'b0;
          for (int i = 0; i < DEPTH; i++) begin
            if (CW'(i) < wn && wa[i] == c_blk[c*ADDR_W +: ADDR_W]) dup = 1'b1;
          end
          if (dup) begin
            inc_bh = inc_bh + 1'b1;
          end else begin
            if (wn == CW'(DEPTH)) begin
              for (int j = 0; j < DEPTH - 1; j++) begin
                wa[j] = wa[j+1];
                wt[j] = wt[j+1];
              end
              wn       = wn - 1'b1;
              inc_full = inc_full + 1'b1;
            end
            wa[wn[IW-1:0]] = c_blk[c*ADDR_W +: ADDR_W];
            wt[wn[IW-1:0]] = c_rdy[c*TIME_W +: TIME_W];
            wn = wn + 1'b1;
          end
        end
      end
    end else if (pop_fire || head_skip) begin
      for (int j = 0; j < DEPTH - 1; j++) begin
        wa[j] = wa[j+1];
        wt[j] = wt[j+1];
      end
      wn = wn - 1'b1;
    end
  end

  // entry storage carries no reset; occupancy qualifies every read
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      qa[i] <= wa[i];
      qt[i] <= wt[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_n       <= '0;
      rpt_valid <= 1'b0;
      rpt_time  <= '0;
    end else begin
      q_n       <= wn;
      rpt_valid <= ntf_valid;
      if (ntf_valid) rpt_time <= (wn != '0) ? wt[0] : '0;
    end
  end

  assign inc_vec[int'(EV_DEMAND)*INC_W +: INC_W] = INC_W'(inc_dem);
  assign inc_vec[int'(EV_SQUASH)*INC_W +: INC_W] = INC_W'(inc_sq);
  assign inc_vec[int'(EV_BUFHIT)*INC_W +: INC_W] = INC_W'(inc_bh);
  assign inc_vec[int'(EV_FULL)*INC_W   +: INC_W] = INC_W'(inc_full);

  pfq_stats #(.CNT_W(CNT_W), .INC_W(INC_W), .NEVENT(PFQ_NEVENT)) u_stats (
    .clk(clk),
    .rst(rst),
    .inc(inc_vec),
    .cnt(cnt_vec)
  );

  assign cnt_demand = cnt_vec[int'(EV_DEMAND)*CNT_W +: CNT_W];
  assign cnt_squash = cnt_vec[int'(EV_SQUASH)*CNT_W +: CNT_W];
  assign cnt_bufhit = cnt_vec[int'(EV_BUFHIT)*CNT_W +: CNT_W];
  assign cnt_full   = cnt_vec[int'(EV_FULL)*CNT_W   +: CNT_W];

  // occupancy bound across eviction and admission
  assert_occupancy_bound_R7: assert property (@(posedge clk) disable iff (rst)
    q_n <= CW'(DEPTH));

  // ignored notifies leave the occupancy untouched
  assert_ignored_notify_R2: assert property (@(posedge clk) disable iff (rst)
    (ntf_valid && (ntf_uncache || (ntf_ifetch && cfg_data_only))) |=> q_n == $past(q_n));

  // a pop handshake removes exactly one entry
  assert_pop_one_R11: assert property (@(posedge clk) disable iff (rst)
    (pop_valid && pop_ready) |=> q_n == $past(q_n) - 1'b1);

  // demand match advances the removal counter by one
  assert_demand_count_R3: assert property (@(posedge clk) disable iff (rst)
    (act && hit) |=> cnt_demand == $past(cnt_demand) + 1'b1);

  // squash counter frozen while the mode is off
  assert_no_squash_R4: assert property (@(posedge clk) disable iff (rst)
    (ntf_valid && !cfg_serial_squash) |=> $stable(cnt_squash));
endmodule

// File: tb/pf_req_queue_bench.sv
`timescale 1ns/1ps
module pf_req_queue_bench;
  localparam int AW = 32, TW = 32, DW = 8, DEPTH = 8, NC = 2, CW16 = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst;
  logic cfg_data_only, cfg_serial_squash, cfg_check_push;
  logic ntf_valid, ntf_uncache, ntf_ifetch;
  logic [AW-1:0] ntf_addr;
  logic [TW-1:0] ntf_time;
  logic [NC-1:0] cand_valid, cand_in_cache, cand_in_missq;
  logic [NC*AW-1:0] cand_addr;
  logic [NC*DW-1:0] cand_delay;
  logic [AW-1:0] head_lkp_addr, pop_addr;
  logic head_lkp_in_cache, pop_valid, pop_ready, rpt_valid;
  logic [TW-1:0] rpt_time, next_ready;
  logic [CW16-1:0] cnt_demand, cnt_squash, cnt_bufhit, cnt_full;

  pf_req_queue u_pf_req_queue (
    .clk(clk), .rst(rst),
    .cfg_data_only(cfg_data_only), .cfg_serial_squash(cfg_serial_squash),
    .cfg_check_push(cfg_check_push),
    .ntf_valid(ntf_valid), .ntf_addr(ntf_addr), .ntf_time(ntf_time),
    .ntf_uncache(ntf_uncache), .ntf_ifetch(ntf_ifetch),
    .cand_valid(cand_valid), .cand_addr(cand_addr), .cand_delay(cand_delay),
    .cand_in_cache(cand_in_cache), .cand_in_missq(cand_in_missq),
    .head_lkp_addr(head_lkp_addr), .head_lkp_in_cache(head_lkp_in_cache),
    .pop_valid(pop_valid), .pop_ready(pop_ready), .pop_addr(pop_addr),
    .rpt_valid(rpt_valid), .rpt_time(rpt_time), .next_ready(next_ready),
    .cnt_demand(cnt_demand), .cnt_squash(cnt_squash),
    .cnt_bufhit(cnt_bufhit), .cnt_full(cnt_full)
  );

  int checks = 0, errors = 0;
  logic done = 1'b0;

  // reference queue and expected counters
  logic [31:0] mq_a[$], mq_t[$];
  int e_dem = 0, e_sq = 0, e_bh = 0, e_full = 0;
  logic e_rv = 1'b0;
  logic [31:0] e_rt = '0;
  logic [31:0] tnow = 32'd100;

  function automatic logic [31:0] align(input logic [31:0] a);
    return {a[31:6], 6'd0};
  endfunction
  function automatic logic cache_fn(input logic [31:0] a);
    return a[8:6] == 3'd5;
  endfunction
  function automatic logic missq_fn(input logic [31:0] a);
    return a[8:6] == 3'd2;
  endfunction
  // n-th block whose index avoids the cached and missing patterns
  function automatic logic [31:0] free_blk(input int n);
    int k = 0, seen = 0;
    while (1) begin
      if ((k % 8) != 2 && (k % 8) != 5) begin
        if (seen == n) return 32'h10000 + k * 64;
        seen++;
      end
      k++;
    end
  endfunction

  always_comb head_lkp_in_cache = cache_fn(head_lkp_addr);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_cand(input int c, input logic v, input logic [31:0] a, input logic [7:0] d);
    cand_valid[c] = v;
    cand_addr[c*AW +: AW] = a;
    cand_delay[c*DW +: DW] = d;
    cand_in_cache[c] = cache_fn(align(a));
    cand_in_missq[c] = missq_fn(align(a));
  endtask

  task automatic idle_inputs();
    ntf_valid = 0; ntf_uncache = 0; ntf_ifetch = 0; ntf_addr = '0; ntf_time = tnow;
    pop_ready = 0;
    for (int c = 0; c < NC; c++) set_cand(c, 1'b0, 32'h0, 8'd0);
  endtask

  task automatic model_step();
    logic act;
    act = ntf_valid && !ntf_uncache && !(ntf_ifetch && cfg_data_only);
    if (act) begin
      logic [31:0] b;
      b = align(ntf_addr);
      for (int i = 0; i < mq_a.size(); i++) begin
        if (mq_a[i] == b) begin mq_a.delete(i); mq_t.delete(i); e_dem++; break; end
      end
      if (cfg_serial_squash) begin
        while (mq_a.size() > 0 && mq_t[$] >= ntf_time) begin
          void'(mq_a.pop_back()); void'(mq_t.pop_back()); e_sq++;
        end
      end
      for (int c = 0; c < NC; c++) begin
        logic [31:0] cb;
        logic found;
        cb = align(cand_addr[c*AW +: AW]);
        found = 1'b0;
        if (!cand_valid[c]) continue;
        if (cfg_check_push && cache_fn(cb)) continue;
        if (missq_fn(cb)) continue;
        foreach (mq_a[i]) if (mq_a[i] == cb) found = 1'b1;
        if (found) begin e_bh++; continue; end
        if (mq_a.size() == DEPTH) begin void'(mq_a.pop_front()); void'(mq_t.pop_front()); e_full++; end
        mq_a.push_back(cb);
        mq_t.push_back(ntf_time + 32'(cand_delay[c*DW +: DW]));
      end
    end else if (!ntf_valid && mq_a.size() > 0) begin
      if (!cfg_check_push && cache_fn(mq_a[0])) begin
        void'(mq_a.pop_front()); void'(mq_t.pop_front());
      end else if (pop_ready) begin
        void'(mq_a.pop_front()); void'(mq_t.pop_front());
      end
    end
    e_rv = ntf_valid;
    if (ntf_valid) e_rt = (mq_a.size() > 0) ? mq_t[0] : 32'd0;
  endtask

  // inputs already driven after a falling edge; checks pop side, then the edge
  task automatic finish_cycle();
    logic exp_pv;
    #1;
    exp_pv = !ntf_valid && mq_a.size() > 0 && (cfg_check_push || !cache_fn(mq_a[0]));
    chk("R11 pop_valid (R6 pop-time cache check)", {31'd0, pop_valid}, {31'd0, exp_pv});
    if (exp_pv) chk("R8 pop_addr order", pop_addr, mq_a[0]);
    model_step();
    @(posedge clk);
    #1;
    chk("R10 next_ready", next_ready, (mq_a.size() > 0) ? mq_t[0] : 32'hFFFF_FFFF);
    chk("R9 rpt_valid", {31'd0, rpt_valid}, {31'd0, e_rv});
    if (e_rv) chk("R9 rpt_time", rpt_time, e_rt);
    chk("R3 cnt_demand", {16'd0, cnt_demand}, 32'(e_dem));
    chk("R4 cnt_squash", {16'd0, cnt_squash}, 32'(e_sq));
    chk("R5 cnt_bufhit", {16'd0, cnt_bufhit}, 32'(e_bh));
    chk("R7 cnt_full", {16'd0, cnt_full}, 32'(e_full));
    @(negedge clk);
  endtask

  initial begin
    int n;
    void'($urandom(32'd2024));
    rst = 1;
    cfg_data_only = 1; cfg_serial_squash = 0; cfg_check_push = 1;
    idle_inputs();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    #1;
    chk("R1 pop_valid", {31'd0, pop_valid}, 32'd0);
    chk("R1 next_ready", next_ready, 32'hFFFF_FFFF);
    chk("R1 rpt_valid", {31'd0, rpt_valid}, 32'd0);
    chk("R1 counters", {cnt_demand | cnt_squash, cnt_bufhit | cnt_full}, 32'd0);

    // R2: uncacheable notify with candidates
    idle_inputs();
    ntf_valid = 1; ntf_uncache = 1; ntf_addr = free_blk(0);
    set_cand(0, 1, free_blk(1), 8'd3); set_cand(1, 1, free_blk(2), 8'd4);
    finish_cycle();
    chk("R2 uncacheable ignored", next_ready, 32'hFFFF_FFFF);
    // R2: fetch notify in data-only mode
    idle_inputs();
    ntf_valid = 1; ntf_ifetch = 1; ntf_addr = free_blk(0);
    set_cand(0, 1, free_blk(1), 8'd3);
    finish_cycle();
    chk("R2 fetch ignored in data-only", next_ready, 32'hFFFF_FFFF);

    // R7/R8: overfill with distinct blocks, unaligned offsets
    n = 1;
    for (int r = 0; r < 5; r++) begin
      idle_inputs();
      ntf_valid = 1; ntf_addr = free_blk(40); ntf_time = tnow;
      set_cand(0, 1, free_blk(n) + 32'd5, 8'(r)); set_cand(1, 1, free_blk(n + 1) + 32'd17, 8'(r + 2));
      n += 2;
      finish_cycle();
    end
    chk("R7 two full evictions", {16'd0, cnt_full}, 32'd2);
    chk("R8 head after eviction", pop_addr, free_blk(3));

    // R3: demand removes a queued block; R5 duplicate in same notify
    idle_inputs();
    ntf_valid = 1; ntf_addr = free_blk(5) + 32'd9;
    set_cand(0, 1, free_blk(30), 8'd1); set_cand(1, 1, free_blk(30) + 32'd1, 8'd1);
    finish_cycle();
    chk("R3 demand removal", {16'd0, cnt_demand}, 32'd1);
    chk("R5 same-notify duplicate", {16'd0, cnt_bufhit}, 32'd1);

    // R4: squash everything not yet matured
    cfg_serial_squash = 1;
    idle_inputs();
    ntf_valid = 1; ntf_addr = free_blk(41); ntf_time = tnow;
    finish_cycle();
    chk("R4 squash emptied queue", next_ready, 32'hFFFF_FFFF);
    cfg_serial_squash = 0;

    // random mix
    for (int cyc = 0; cyc < 4000; cyc++) begin
      if (cyc % 250 == 0) begin
        cfg_data_only = $urandom % 2; cfg_serial_squash = ($urandom % 4) == 0;
        cfg_check_push = $urandom % 2;
      end
      tnow = tnow + 32'($urandom % 3);
      idle_inputs();
      ntf_valid = ($urandom % 2) == 0;
      ntf_uncache = ($urandom % 8) == 0;
      ntf_ifetch = ($urandom % 4) == 0;
      ntf_addr = 32'h10000 + ($urandom % 32) * 64 + ($urandom % 64);
      ntf_time = tnow;
      pop_ready = $urandom % 2;
      for (int c = 0; c < NC; c++) begin
        logic [31:0] a;
        if ($urandom % 2) a = align(ntf_addr) + (1 + $urandom % 4) * 64 + ($urandom % 64);
        else a = 32'h10000 + ($urandom % 32) * 64 + ($urandom % 64);
        set_cand(c, ($urandom % 4) != 0, a, 8'($urandom % 16));
      end
      finish_cycle();
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R11 actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule